// File: doc/BRIEF.md
# Chained Serial Converter Readout Controller

This controller sits on the host side of a string of identical successive-approximation converters that share one convert strobe and one serial clock. Each converter's serial input is fed from the next converter's output, so the string reads out like one long shift register. Only the converter nearest the host drives the host's data input. A start request raises the strobe while the serial clock is low, which starts conversion in every device and selects the chained mode without a busy indicator. The controller then waits a fixed number of system clocks for conversion and generates one serial clock pulse for every bit in the chain. It shifts in the returned bits and finally presents every device's result in parallel with a one-cycle valid flag.

The device count, word width, conversion wait, serial clock half-period and capture edge are all parameters. Capturing on the falling serial clock edge lets the serial clock run faster, as long as the host's hold time allows it. Capturing on the rising edge gives more margin at lower rates. Readout time grows linearly with the number of chained devices. This limits the achievable conversion rate.

Top module: `chain_adc_reader`

## Requirements
- R1: While idle, `sck` and `cnv` are low. A `start` sampled high while idle raises `cnv` after that clock edge, and `sck` is low in the cycle where `cnv` rises.
- R2: `cnv` stays high without a break from its rising edge until the last serial clock pulse ends, and `busy` is high for exactly that span.
- R3: The first rising edge of `sck` comes CONV_CYCLES + SCK_HALF clock edges after the edge that sampled `start`.
- R4: Each `sck` pulse is high for SCK_HALF clocks and low for SCK_HALF clocks. Exactly NUM_DEV × WORD_BITS pulses are issued per transaction.
- R5: With SAMPLE_FALL = 1, `adc_sdo` is captured at the clock edge where `sck` falls. With SAMPLE_FALL = 0, it is captured at the edge where `sck` rises. In both cases the first bit is the value present before the first pulse.
- R6: Bits arrive most significant first. The first WORD_BITS bits received form device 0, the device nearest the host, and appear on `words[WORD_BITS-1:0]`. Device i appears on `words[i*WORD_BITS +: WORD_BITS]`.
- R7: `valid` rises CONV_CYCLES + 2 × NUM_DEV × WORD_BITS × SCK_HALF clock edges after the edge that sampled `start`. It stays high for one cycle, `cnv` is low in that cycle, and `busy` is low in the cycle after unless a new start was accepted.
- R8: `words` changes only at the edge where `valid` rises, and holds its value until the next such edge.
- R9: A `start` while `busy` is ignored. It neither shortens nor lengthens the running transaction and does not start another one.
- R10: A `start` sampled during the `valid` cycle is accepted at once. The next `valid` then follows exactly one transaction length plus one clock later.
- R11: After reset, `cnv`, `sck`, `valid` and `busy` are low and `words` is zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Request one conversion and readout |
| adc_sdo | input | 1 | Serial data from the device nearest the host |
| cnv | output | 1 | Convert strobe shared by all devices |
| sck | output | 1 | Serial clock shared by all devices |
| busy | output | 1 | Transaction in progress |
| valid | output | 1 | One-cycle pulse: `words` has just been updated |
| words | output | NUM_DEV*WORD_BITS | Captured results, device i at bits i*WORD_BITS upward |

## Verification
A new start request can fall in the same cycle as the completion pulse of the previous transaction. The bench provokes this by holding `start` high across a whole transaction. It then checks that the restart is taken immediately, that the second `valid` arrives exactly one transaction length plus one clock after the first, and that the earlier words stay unchanged until that second pulse. A second overlap is a start request arriving mid-readout. This is judged by checking that the completion latency and the captured words are the same as in an undisturbed run. Two instances with different device counts, divide ratios and capture edges are each driven by a behavioural chain model.

// File: rtl/chain_adc_reader.sv
module chain_adc_reader #(
  parameter int NUM_DEV     = 2,
  parameter int WORD_BITS   = 18,
  parameter int CONV_CYCLES = 20,
  parameter int SCK_HALF    = 2,
  parameter bit SAMPLE_FALL = 1'b1
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           start,
  input  logic                           adc_sdo,
  output logic                           cnv,
  output logic                           sck,
  output logic                           busy,
  output logic                           valid,
  output logic [NUM_DEV*WORD_BITS-1:0]   words
);

  localparam int TOTAL = NUM_DEV * WORD_BITS;
  localparam int CW    = $clog2(CONV_CYCLES + 1);
  localparam int DW    = $clog2(SCK_HALF + 1);
  localparam int BW    = $clog2(TOTAL + 1);

  typedef enum logic [1:0] {ST_IDLE, ST_CONV, ST_READ} state_t;

  state_t           state;
  logic [CW-1:0]    conv_cnt;
  logic [DW-1:0]    div_cnt;
  logic [BW-1:0]    bit_cnt;
  logic             sck_q, cnv_q, valid_q;
  logic [TOTAL-1:0] shreg, shreg_nxt, word_map, words_q;

  wire tick      = (state == ST_READ) && (div_cnt == DW'(SCK_HALF - 1));
  wire fall_tick = tick && sck_q;
  wire rise_tick = tick && !sck_q;
  wire sample    = SAMPLE_FALL ? fall_tick : rise_tick;
  wire last      = fall_tick && (bit_cnt == BW'(TOTAL - 1));

  assign shreg_nxt = sample ? {shreg[TOTAL-2:0], adc_sdo} : shreg;

  for (genvar i = 0; i < NUM_DEV; i++) begin : g_map
    assign word_map[i*WORD_BITS +: WORD_BITS] = shreg_nxt[TOTAL-1-i*WORD_BITS -: WORD_BITS];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state    <= ST_IDLE;
      conv_cnt <= '0;
      div_cnt  <= '0;
      bit_cnt  <= '0;
      sck_q    <= 1'b0;
      cnv_q    <= 1'b0;
      valid_q  <= 1'b0;
      shreg    <= '0;
      words_q  <= '0;
    end else begin
      valid_q <= 1'b0;
      shreg   <= shreg_nxt;
      case (state)
        ST_IDLE: if (start) begin
          state    <= ST_CONV;
          cnv_q    <= 1'b1;
          conv_cnt <= '0;
        end
        ST_CONV: if (conv_cnt == CW'(CONV_CYCLES - 1)) begin
          state   <= ST_READ;
          div_cnt <= '0;
          bit_cnt <= '0;
        end else begin
          conv_cnt <= conv_cnt + 1'b1;
        end
        ST_READ: if (tick) begin
          div_cnt <= '0;
          sck_q   <= !sck_q;
          if (fall_tick) bit_cnt <= bit_cnt + 1'b1;
          if (last) begin
            state   <= ST_IDLE;
            cnv_q   <= 1'b0;
            valid_q <= 1'b1;
            words_q <= word_map;
          end
        end else begin
          div_cnt <= div_cnt + 1'b1;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign cnv   = cnv_q;
  assign sck   = sck_q;
  assign busy  = (state != ST_IDLE);
  assign valid = valid_q;
  assign words = words_q;

  logic [BW-1:0] pulse_cnt;
  always_ff @(posedge clk) begin
    if (!rst_n)                        pulse_cnt <= '0;
    else if (state == ST_IDLE && start) pulse_cnt <= '0;
    else if (rise_tick)                pulse_cnt <= pulse_cnt + 1'b1;
  end

  assert_cnv_rise_sck_low_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cnv) |-> !sck);
  assert_sck_inside_cnv_R2: assert property (@(posedge clk) disable iff (!rst_n)
    sck |-> cnv);
  assert_busy_matches_cnv_R2: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> cnv);
  assert_pulse_count_R4: assert property (@(posedge clk) disable iff (!rst_n)
    valid |-> (pulse_cnt == BW'(TOTAL)));
  assert_valid_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
    valid |=> !valid);
  assert_valid_cnv_low_R7: assert property (@(posedge clk) disable iff (!rst_n)
    valid |-> !cnv);
  assert_words_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !valid |-> $stable(words));
  assert_start_ignored_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (cnv && start) |=> (cnv || valid));

endmodule

// File: tb/chain_adc_reader_tb_top.sv
module chain_model #(
  parameter int N = 2,
  parameter int B = 18
) (
  input  logic         cnv,
  input  logic         sck,
  input  logic [N*B-1:0] vals,
  output logic         sdo
);
  localparam int T = N * B;
  logic [T-1:0] sr = '0;
  assign sdo = sr[T-1];
  always begin
    @(posedge cnv);
    for (int i = 0; i < N; i++) sr[T-1-i*B -: B] = vals[i*B +: B];
    while (cnv) begin
      @(negedge sck or negedge cnv);
      if (cnv) begin
        #2;
        sr = sr << 1;
      end
    end
  end
endmodule

module chain_adc_reader_tb_top;
  localparam int NA = 2, BA = 18, CA = 10, DA = 2;
  localparam int NB = 3, BB = 18, CB = 5,  DB = 1;
  localparam int TA = NA*BA, TB = NB*BB;
  localparam int LAT_A = CA + 2*TA*DA;
  localparam int LAT_B = CB + 2*TB*DB;

  logic clk = 0, rst_n = 0, start = 0;
  always #10 clk = ~clk;

  logic [TA-1:0] vals_a = '0, words_a;
  logic [TB-1:0] vals_b = '0, words_b;
  logic sdo_a, sdo_b;
  logic cnv[2], sck[2], busy[2], valid[2];

  int checks = 0, fails = 0, cyc = 0;

  chain_adc_reader #(.NUM_DEV(NA), .WORD_BITS(BA), .CONV_CYCLES(CA), .SCK_HALF(DA), .SAMPLE_FALL(1'b1)) dut_i (
    .clk(clk), .rst_n(rst_n), .start(start), .adc_sdo(sdo_a),
    .cnv(cnv[0]), .sck(sck[0]), .busy(busy[0]), .valid(valid[0]), .words(words_a));
  chain_adc_reader #(.NUM_DEV(NB), .WORD_BITS(BB), .CONV_CYCLES(CB), .SCK_HALF(DB), .SAMPLE_FALL(1'b0)) dut_r (
    .clk(clk), .rst_n(rst_n), .start(start), .adc_sdo(sdo_b),
    .cnv(cnv[1]), .sck(sck[1]), .busy(busy[1]), .valid(valid[1]), .words(words_b));

  chain_model #(.N(NA), .B(BA)) model_a (.cnv(cnv[0]), .sck(sck[0]), .vals(vals_a), .sdo(sdo_a));
  chain_model #(.N(NB), .B(BB)) model_b (.cnv(cnv[1]), .sck(sck[1]), .vals(vals_b), .sdo(sdo_b));

  task automatic chk(input bit ok, input string req, input string what, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic logic [17:0] pat(input int t, input int i);
    case (t)
      0: pat = 18'h00000;
      1: pat = 18'h3FFFF;
      2: pat = (i % 2) ? 18'h15555 : 18'h2AAAA;
      3: pat = 18'h1 << ((i * 5) % 18);
      default: pat = 18'((t * 40503 + i * 9973 + 341) ^ (t << (i + 3)));
    endcase
  endfunction

  task automatic load_vals(input int t);
    for (int i = 0; i < NA; i++) vals_a[i*BA +: BA] = pat(t, i);
    for (int i = 0; i < NB; i++) vals_b[i*BB +: BB] = pat(t + 1, i);
  endtask

  task automatic run_txn(input bit poke);
    int lat[2], first[2], rises[2];
    bit prev[2], cnvbad[2], done[2], cnvlow[2];
    for (int d = 0; d < 2; d++) begin
      lat[d] = -1; first[d] = -1; rises[d] = 0; prev[d] = 0;
      cnvbad[d] = 0; done[d] = 0; cnvlow[d] = 0;
    end
    start = 1;
    @(negedge clk);
    start = 0;
    for (int k = 0; k < 400; k++) begin
      for (int d = 0; d < 2; d++) if (!done[d]) begin
        if (k == 0) begin
          chk(cnv[d] && !sck[d], "R1", "cnv high with sck low after start", {cnv[d], sck[d]}, 2'b10);
          chk(busy[d], "R2", "busy after start", busy[d], 1);
        end
        if (sck[d] && !prev[d]) begin
          rises[d]++;
          if (first[d] < 0) first[d] = k;
        end
        prev[d] = sck[d];
        if (valid[d]) begin
          lat[d] = k; done[d] = 1; cnvlow[d] = !cnv[d];
        end else if (!cnv[d] || !busy[d]) cnvbad[d] = 1;
      end
      if (done[0] && done[1]) break;
      if (poke && k == 20) start = 1;
      if (poke && k == 21) start = 0;
      @(negedge clk);
    end
    chk(lat[0] == LAT_A, poke ? "R9" : "R7", "latency A", lat[0], LAT_A);
    chk(lat[1] == LAT_B, poke ? "R9" : "R7", "latency B", lat[1], LAT_B);
    chk(first[0] == CA + DA, "R3", "first sck rise A", first[0], CA + DA);
    chk(first[1] == CB + DB, "R3", "first sck rise B", first[1], CB + DB);
    chk(rises[0] == TA, "R4", "pulse count A", rises[0], TA);
    chk(rises[1] == TB, "R4", "pulse count B", rises[1], TB);
    chk(cnvlow[0] && cnvlow[1], "R7", "cnv low at valid", {cnvlow[0], cnvlow[1]}, 2'b11);
    chk(!cnvbad[0] && !cnvbad[1], "R2", "cnv/busy gap", {cnvbad[0], cnvbad[1]}, 0);
    chk(words_a == vals_a, "R5", "falling-edge capture words A", words_a, vals_a);
    chk(words_b == vals_b, "R6", "rising-edge capture words B", words_b, vals_b);
    @(negedge clk);
    chk(!valid[0] && !valid[1], "R7", "valid one cycle", {valid[0], valid[1]}, 0);
    chk(!busy[0] && !busy[1], "R9", "idle after done", {busy[0], busy[1]}, 0);
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cyc++;
      if (cyc > 150000) begin
        fails++;
        $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
      end
    end
  end

  initial begin
    logic [TA-1:0] old_a;
    int k2;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    for (int d = 0; d < 2; d++)
      chk(!cnv[d] && !sck[d] && !valid[d] && !busy[d], "R11", "reset outputs",
          {cnv[d], sck[d], valid[d], busy[d]}, 0);
    chk(words_a == 0 && words_b == 0, "R11", "reset words", words_a, 0);

    for (int t = 0; t < 10; t++) begin
      load_vals(t);
      run_txn(t == 4 || t == 7);
      repeat (2) @(negedge clk);
    end

    load_vals(20);
    start = 1;
    @(negedge clk);
    k2 = -1;
    for (int k = 0; k < 700; k++) begin
      if (valid[0] && k == LAT_A) begin
        chk(words_a == vals_a, "R6", "back-to-back first words", words_a, vals_a);
        old_a = vals_a;
        load_vals(21);
      end
      if (k == LAT_A + 1)
        chk(busy[0] && cnv[0], "R10", "restart in valid cycle", {busy[0], cnv[0]}, 2'b11);
      if (k == LAT_A + 60)
        chk(words_a == old_a, "R8", "words held mid-transaction", words_a, old_a);
      if (valid[0] && k > LAT_A) begin
        k2 = k;
        break;
      end
      @(negedge clk);
    end
    start = 0;
    chk(k2 == 2*LAT_A + 1, "R10", "second valid spacing", k2, 2*LAT_A + 1);
    chk(words_a == vals_a, "R8", "words updated on second valid", words_a, vals_a);
    for (int k = 0; k < 500 && (busy[0] || busy[1]); k++) @(negedge clk);
    repeat (2) @(negedge clk);
    chk(!busy[0] && !busy[1] && !cnv[0] && !cnv[1], "R9", "no spurious restart",
        {busy[0], busy[1], cnv[0], cnv[1]}, 0);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule